// File: doc/BRIEF.md
# MOESI Snooping Line Controller

This block keeps the coherence state of a small direct-mapped set of cache lines for one cache on a shared snooping bus. Each line carries a tag, a one-word data value and one of five states: Invalid, Shared, Exclusive, Owned or Modified. The Owned state lets a dirty line be shared. The cache that last wrote the line keeps ownership, supplies the data to other caches and writes it back to memory when it evicts the line. Shared copies are dropped silently.

On the processor side the block accepts one read or write at a time and returns a done pulse. On a miss or an upgrade it posts one bus request and waits for a grant. A dirty victim is written back first. At the same time it snoops every command on the bus. It drives the copies-exist line in the same cycle as a snooped read, and one cycle later it answers with a flush when its state requires one. A read miss completes when memory replies or when another cache flushes the requested address.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and pr_done, bus_req, copies_out and flush_valid are low. The bus command codes are 1 read, 2 read-for-ownership, 3 upgrade, 4 flush, 5 optional flush and 6 write-back. bus_req only ever carries 1, 2, 3 or 6.
- R2: A read miss posts command 1. The line fills as Shared if copies_in is high when memory replies, and as Exclusive otherwise. pr_rdata returns the fill data.
- R3: A write miss posts command 2 and the line fills as Modified holding pr_wdata.
- R4: A write hit on an Exclusive or Modified line completes with no bus request and leaves the line Modified.
- R5: A write hit on a Shared or Owned line posts command 3 and makes the line Modified on the grant. If a snoop invalidates the line before the grant, the pending request turns into command 2.
- R6: A read hit completes with no bus request and no state change. pr_done rises on the second clock edge after pr_valid and lasts one cycle.
- R7: A snooped command 1 to a Modified line returns flush code 4 with the line data and moves the line to Owned. On an Owned line it returns code 4 and the line stays Owned.
- R8: A snooped command 2 to a Modified or Owned line returns code 4 and invalidates the line. A snooped command 3 to an Owned line invalidates it with no flush.
- R9: A snooped command 1 to an Exclusive line returns code 5 and moves the line to Shared. A snooped command 2 returns code 5 and invalidates the line.
- R10: In Shared, a snooped command 1 gives no flush and no change, while commands 2 and 3 invalidate the line with no flush. A line that is Invalid or holds another tag ignores every snooped command.
- R11: Before a miss replaces a Modified or Owned line, the block posts command 6 with the victim's address and data, then the miss request. An Exclusive or Shared victim is replaced without any bus command.
- R12: copies_out is high in the cycle of a snooped command 1 exactly when the addressed line is valid.
- R13: While its own read is outstanding, a snooped code 4 or 5 whose address matches the request completes the miss with the snooped data, and the line fills as Shared. A flush to any other address does not complete it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pr_valid | input | 1 | Processor request, held until pr_done |
| pr_write | input | 1 | 1 = write, 0 = read |
| pr_addr | input | AW | Line address of the request |
| pr_wdata | input | DW | Write data |
| pr_done | output | 1 | One-cycle completion pulse |
| pr_rdata | output | DW | Line data after the access |
| bus_req | output | 1 | Bus request pending |
| bus_req_cmd | output | 3 | Command of the pending request |
| bus_req_addr | output | AW | Address of the pending request |
| bus_req_data | output | DW | Write-back data (command 6) |
| bus_gnt | input | 1 | Grant for the pending request |
| snp_valid | input | 1 | A bus command is visible |
| snp_cmd | input | 3 | Snooped command code |
| snp_addr | input | AW | Snooped address |
| snp_data | input | DW | Snooped flush data |
| copies_out | output | 1 | Drive to the copies-exist line |
| copies_in | input | 1 | Copies-exist line as seen from other caches |
| mem_resp_valid | input | 1 | Memory reply for the outstanding miss |
| mem_resp_data | input | DW | Memory reply data |
| flush_valid | output | 1 | Flush answer to a snoop |
| flush_cmd | output | 3 | Flush code, 4 or 5 |
| flush_addr | output | AW | Address being flushed |
| flush_data | output | DW | Flushed line data |

## Verification
Each result has a fixed due cycle. A hit completes on the second edge after pr_valid. A miss request is visible after that same edge. An upgrade completes on its grant edge. A fill completes one edge after the reply or matching flush is captured. copies_out is due in the snoop cycle itself, and a flush answer one edge after the snoop. The bench drives on falling edges and samples at the falling edge where each result is due. It checks the hit latency as an exact count of edges, and it records any bus request raised during a hit. The state of a line is never read directly. The bench infers it from the next snoop's copies and flush answer, or from the command that the next write posts.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_RD       = 3'd1,
    CMD_RDX      = 3'd2,
    CMD_UPGR     = 3'd3,
    CMD_FLUSH    = 3'd4,
    CMD_FLUSHOPT = 3'd5,
    CMD_FLUSHWB  = 3'd6
  } bus_cmd_e;

  // state a line takes after observing another cache's command
  function automatic line_st_e snoop_next(line_st_e s, bus_cmd_e c);
    case (c)
      CMD_RD:   return (s == ST_M || s == ST_O) ? ST_O : (s == ST_E) ? ST_S : s;
      CMD_RDX,
      CMD_UPGR: return ST_I;
      default:  return s;
    endcase
  endfunction

  // data answer owed to another cache's command
  function automatic bus_cmd_e snoop_reply(line_st_e s, bus_cmd_e c);
    if (c != CMD_RD && c != CMD_RDX) return CMD_NONE;
    if (s == ST_M || s == ST_O)      return CMD_FLUSH;
    if (s == ST_E)                   return CMD_FLUSHOPT;
    return CMD_NONE;
  endfunction

  function automatic logic holds_dirty(line_st_e s);
    return (s == ST_M) || (s == ST_O);
  endfunction

  function automatic line_st_e read_fill_state(logic shared);
    return shared ? ST_S : ST_E;
  endfunction

endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
  import moesi_pkg::*;
#(
  parameter int IDXW = 2,
  parameter int TAGW = 6,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] a_idx,
  output logic [TAGW-1:0] a_tag,
  output line_st_e        a_st,
  output logic [DW-1:0]   a_data,
  input  logic [IDXW-1:0] b_idx,
  output logic [TAGW-1:0] b_tag,
  output line_st_e        b_st,
  output logic [DW-1:0]   b_data,
  input  logic            we,
  input  logic [IDXW-1:0] w_idx,
  input  logic [TAGW-1:0] w_tag,
  input  line_st_e        w_st,
  input  logic            w_data_we,
  input  logic [DW-1:0]   w_data
);
  localparam int NL = 1 << IDXW;

  line_st_e        st_v  [NL];
  logic [TAGW-1:0] tag_v [NL];
  logic [DW-1:0]   dat_v [NL];

  for (genvar l = 0; l < NL; l++) begin : g_line
    line_st_e        st_r;
    logic [TAGW-1:0] tag_r;
    logic [DW-1:0]   dat_r;
    wire             sel = we && (w_idx == IDXW'(l));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_r <= ST_I;
      else if (sel) st_r <= w_st;
    end

    always_ff @(posedge clk) begin
      if (sel)              tag_r <= w_tag;
      if (sel && w_data_we) dat_r <= w_data;
    end

    assign st_v[l]  = st_r;
    assign tag_v[l] = tag_r;
    assign dat_v[l] = dat_r;
  end

  assign a_st   = st_v[a_idx];
  assign a_tag  = tag_v[a_idx];
  assign a_data = dat_v[a_idx];
  assign b_st   = st_v[b_idx];
  assign b_tag  = tag_v[b_idx];
  assign b_data = dat_v[b_idx];
endmodule

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
  import moesi_pkg::*;
#(
  parameter int AW   = 8,
  parameter int IDXW = 2,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid,
  input  bus_cmd_e      snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  line_st_e      line_st,
  input  logic [AW-IDXW-1:0] line_tag,
  input  logic [DW-1:0] line_data,
  output logic          copies,
  output logic          upd,
  output line_st_e      upd_st,
  output logic          flush_valid,
  output bus_cmd_e      flush_cmd,
  output logic [AW-1:0] flush_addr,
  output logic [DW-1:0] flush_data
);
  logic     s_hit;
  bus_cmd_e reply;

  assign s_hit  = snp_valid && (line_st != ST_I) && (line_tag == snp_addr[AW-1:IDXW]);
  assign reply  = snoop_reply(line_st, snp_cmd);
  assign upd_st = snoop_next(line_st, snp_cmd);
  assign upd    = s_hit && (upd_st != line_st);
  assign copies = s_hit && (snp_cmd == CMD_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_valid <= 1'b0;
      flush_cmd   <= CMD_NONE;
      flush_addr  <= '0;
      flush_data  <= '0;
    end else begin
      flush_valid <= s_hit && (reply != CMD_NONE);
      if (s_hit && (reply != CMD_NONE)) begin
        flush_cmd  <= reply;
        flush_addr <= snp_addr;
        flush_data <= line_data;
      end
    end
  end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int AW   = 8,
  parameter int IDXW = 2,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pr_valid,
  input  logic          pr_write,
  input  logic [AW-1:0] pr_addr,
  input  logic [DW-1:0] pr_wdata,
  output logic          pr_done,
  output logic [DW-1:0] pr_rdata,
  output logic          bus_req,
  output logic [2:0]    bus_req_cmd,
  output logic [AW-1:0] bus_req_addr,
  output logic [DW-1:0] bus_req_data,
  input  logic          bus_gnt,
  input  logic          snp_valid,
  input  logic [2:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data,
  output logic          copies_out,
  input  logic          copies_in,
  input  logic          mem_resp_valid,
  input  logic [DW-1:0] mem_resp_data,
  output logic          flush_valid,
  output logic [2:0]    flush_cmd,
  output logic [AW-1:0] flush_addr,
  output logic [DW-1:0] flush_data
);
  localparam int TAGW = AW - IDXW;

  typedef enum logic [2:0] {F_IDLE, F_LOOK, F_WB, F_REQ, F_WAIT, F_FILL} fsm_e;

  fsm_e          fsm, fsm_nx;
  logic          rq_write, fill_shared;
  logic [AW-1:0] rq_addr;
  logic [DW-1:0] rq_wdata, fill_data;

  bus_cmd_e        s_cmd, f_cmd;
  logic [IDXW-1:0] p_idx;
  logic [TAGW-1:0] p_tag, p_tag_r, s_tag_r;
  line_st_e        p_st, s_st, snp_st;
  logic [DW-1:0]   p_data, s_data;
  logic            snp_upd;

  assign s_cmd = bus_cmd_e'(snp_cmd);
  assign p_idx = rq_addr[IDXW-1:0];
  assign p_tag = rq_addr[AW-1:IDXW];

  // named events for the checker
  logic p_hit, victim_dirty, want_upgr, granted;
  logic ev_wb_grant, ev_fill_flush, ev_fill_mem, ev_fill_cap;
  bus_cmd_e want_cmd;

  assign p_hit        = (p_st != ST_I) && (p_tag_r == p_tag);
  assign victim_dirty = holds_dirty(p_st) && (p_tag_r != p_tag);
  assign want_upgr    = rq_write && p_hit && (p_st == ST_S || p_st == ST_O);
  assign want_cmd     = !rq_write ? CMD_RD : (want_upgr ? CMD_UPGR : CMD_RDX);
  assign bus_req      = (fsm == F_REQ) || (fsm == F_WB && victim_dirty);
  assign bus_req_cmd  = !bus_req ? CMD_NONE : (fsm == F_WB ? CMD_FLUSHWB : want_cmd);
  assign bus_req_addr = (fsm == F_WB) ? {p_tag_r, p_idx} : rq_addr;
  assign bus_req_data = (fsm == F_WB) ? p_data : '0;
  assign granted      = bus_req && bus_gnt && !snp_valid;
  assign ev_wb_grant  = granted && (fsm == F_WB);
  assign ev_fill_flush = (fsm == F_WAIT) && snp_valid && (snp_addr == rq_addr)
                         && (s_cmd == CMD_FLUSH || s_cmd == CMD_FLUSHOPT);
  assign ev_fill_mem  = (fsm == F_WAIT) && !ev_fill_flush && mem_resp_valid;
  assign ev_fill_cap  = ev_fill_flush || ev_fill_mem;

  moesi_line_store #(.IDXW(IDXW), .TAGW(TAGW), .DW(DW)) u_store (
    .clk, .rst_n,
    .a_idx(p_idx), .a_tag(p_tag_r), .a_st(p_st), .a_data(p_data),
    .b_idx(snp_addr[IDXW-1:0]), .b_tag(s_tag_r), .b_st(s_st), .b_data(s_data),
    .we(w_en), .w_idx(w_idx), .w_tag(w_tag), .w_st(w_st),
    .w_data_we(w_data_we), .w_data(w_data)
  );

  moesi_snoop_unit #(.AW(AW), .IDXW(IDXW), .DW(DW)) u_snoop (
    .clk, .rst_n,
    .snp_valid, .snp_cmd(s_cmd), .snp_addr,
    .line_st(s_st), .line_tag(s_tag_r), .line_data(s_data),
    .copies(copies_out), .upd(snp_upd), .upd_st(snp_st),
    .flush_valid, .flush_cmd(f_cmd), .flush_addr, .flush_data
  );
  assign flush_cmd = f_cmd;

  // processor-side write request; every branch requires a quiet snoop bus
  logic          f_we, f_data_we, done_now;
  logic [TAGW-1:0] f_tag;
  line_st_e      f_st;
  logic [DW-1:0] f_data, done_data;

  always_comb begin
    fsm_nx = fsm;
    f_we = 1'b0; f_data_we = 1'b0; f_tag = p_tag; f_st = ST_I; f_data = rq_wdata;
    done_now = 1'b0; done_data = rq_wdata;
    case (fsm)
      F_IDLE: if (pr_valid) fsm_nx = F_LOOK;
      F_LOOK: if (!snp_valid) begin
        if (p_hit && !rq_write) begin
          done_now = 1'b1; done_data = p_data; fsm_nx = F_IDLE;
        end else if (p_hit && (p_st == ST_E || p_st == ST_M)) begin
          f_we = 1'b1; f_data_we = 1'b1; f_st = ST_M;
          done_now = 1'b1; fsm_nx = F_IDLE;
        end else begin
          fsm_nx = (!p_hit && victim_dirty) ? F_WB : F_REQ;
        end
      end
      F_WB: if (!victim_dirty) fsm_nx = F_REQ;
            else if (granted) begin
              f_we = 1'b1; f_tag = p_tag_r; f_st = ST_I; fsm_nx = F_REQ;
            end
      F_REQ: if (granted) begin
        if (want_cmd == CMD_UPGR) begin
          f_we = 1'b1; f_data_we = 1'b1; f_st = ST_M;
          done_now = 1'b1; fsm_nx = F_IDLE;
        end else fsm_nx = F_WAIT;
      end
      F_WAIT: if (ev_fill_cap) fsm_nx = F_FILL;
      F_FILL: if (!snp_valid) begin
        f_we = 1'b1; f_data_we = 1'b1;
        f_st   = rq_write ? ST_M : read_fill_state(fill_shared);
        f_data = rq_write ? rq_wdata : fill_data;
        done_now = 1'b1; done_data = f_data; fsm_nx = F_IDLE;
      end
      default: fsm_nx = F_IDLE;
    endcase
  end

  logic            w_en, w_data_we;
  logic [IDXW-1:0] w_idx;
  logic [TAGW-1:0] w_tag;
  line_st_e        w_st;
  logic [DW-1:0]   w_data;

  assign w_en      = snp_upd || f_we;
  assign w_idx     = snp_upd ? snp_addr[IDXW-1:0] : p_idx;
  assign w_tag     = snp_upd ? s_tag_r : f_tag;
  assign w_st      = snp_upd ? snp_st : f_st;
  assign w_data_we = !snp_upd && f_data_we;
  assign w_data    = f_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm <= F_IDLE;
      rq_write <= 1'b0; rq_addr <= '0; rq_wdata <= '0;
      fill_data <= '0; fill_shared <= 1'b0;
      pr_done <= 1'b0; pr_rdata <= '0;
    end else begin
      fsm     <= fsm_nx;
      pr_done <= done_now;
      if (done_now) pr_rdata <= done_data;
      if (fsm == F_IDLE && pr_valid) begin
        rq_write <= pr_write; rq_addr <= pr_addr; rq_wdata <= pr_wdata;
      end
      if (ev_fill_cap) begin
        fill_data   <= ev_fill_flush ? snp_data : mem_resp_data;
        fill_shared <= ev_fill_flush || copies_in;
      end
    end
  end
endmodule

// File: rtl/moesi_line_chk.sv
module moesi_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pr_done,
  input logic       bus_req,
  input logic [2:0] bus_req_cmd,
  input logic       snp_valid,
  input logic [2:0] snp_cmd,
  input logic       copies_out,
  input logic       flush_valid,
  input logic       ev_wb_grant
);
  a_r1_req_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_req_cmd == 3'd1 || bus_req_cmd == 3'd2 ||
                 bus_req_cmd == 3'd3 || bus_req_cmd == 3'd6));

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pr_done |=> !pr_done);

  a_r12_copies_on_read_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    copies_out |-> (snp_valid && snp_cmd == 3'd1));

  a_r8_flush_after_read_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd2)));

  a_r10_upgrade_never_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 3'd3) |=> !flush_valid);

  a_r11_writeback_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_grant |=> (bus_req && bus_req_cmd != 3'd6));
endmodule

bind moesi_line_ctrl moesi_line_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pr_done(pr_done), .bus_req(bus_req),
  .bus_req_cmd(bus_req_cmd), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .copies_out(copies_out), .flush_valid(flush_valid), .ev_wb_grant(ev_wb_grant)
);

// File: tb/sim_moesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_moesi_line_ctrl;
  localparam int AW = 8, DW = 16;
  localparam logic [2:0] C_NO = 3'd0, C_RD = 3'd1, C_RDX = 3'd2, C_UPG = 3'd3,
                         C_FL = 3'd4, C_FLO = 3'd5, C_WB = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pr_valid = 0, pr_write = 0;
  logic [AW-1:0] pr_addr = '0;
  logic [DW-1:0] pr_wdata = '0;
  logic pr_done, bus_req, copies_out, flush_valid;
  logic [DW-1:0] pr_rdata, bus_req_data, flush_data;
  logic [2:0] bus_req_cmd, flush_cmd;
  logic [AW-1:0] bus_req_addr, flush_addr;
  logic bus_gnt = 0, snp_valid = 0, copies_in = 0, mem_resp_valid = 0;
  logic [2:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_data = '0, mem_resp_data = '0;

  int total = 0, bad = 0;
  bit bus_seen = 0;

  always #10 clk = ~clk;

  moesi_line_ctrl #(.AW(AW), .IDXW(2), .DW(DW)) u0 (.*);

  always @(negedge clk) if (bus_req) bus_seen = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic proc_start(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    pr_valid = 1; pr_write = wr; pr_addr = a; pr_wdata = d; bus_seen = 0;
  endtask

  task automatic wait_done(input string req, output logic [DW-1:0] rd);
    int n = 0;
    while (!pr_done && n < 60) begin @(negedge clk); n++; end
    chk(pr_done, req, "done", {31'd0, pr_done}, 1);
    rd = pr_rdata;
    pr_valid = 0;
  endtask

  task automatic hit_access(input string req, input bit wr, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic [DW-1:0] exp_rd);
    int n = 0;
    proc_start(wr, a, d);
    do begin @(negedge clk); n++; end while (!pr_done && n < 20);
    chk(n == 2, req, "hit latency", n, 2);
    chk(pr_rdata == exp_rd, req, "hit data", pr_rdata, exp_rd);
    chk(!bus_seen, req, "no bus on hit", {31'd0, bus_seen}, 0);
    pr_valid = 0;
  endtask

  task automatic expect_req(input string req, input logic [2:0] c, input logic [AW-1:0] a,
                            input bit chk_d, input logic [DW-1:0] d);
    int n = 0;
    while (!bus_req && n < 20) begin @(negedge clk); n++; end
    chk(bus_req && bus_req_cmd == c && bus_req_addr == a, req, "bus request",
        {bus_req_cmd, 5'd0, bus_req_addr}, {c, 5'd0, a});
    if (chk_d) chk(bus_req_data == d, req, "write-back data", bus_req_data, d);
    bus_gnt = 1;
    @(posedge clk); @(negedge clk);
    bus_gnt = 0;
  endtask

  task automatic mem_reply(input logic [DW-1:0] d, input bit cp);
    @(negedge clk);
    mem_resp_valid = 1; mem_resp_data = d; copies_in = cp;
    @(posedge clk); @(negedge clk);
    mem_resp_valid = 0; copies_in = 0;
  endtask

  task automatic snoop(input string req, input logic [2:0] c, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit exp_cp, input logic [2:0] exp_fl,
                       input logic [DW-1:0] exp_fd);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a; snp_data = d;
    #1;
    chk(copies_out == exp_cp, req, "copies_out", {31'd0, copies_out}, {31'd0, exp_cp});
    @(posedge clk); @(negedge clk);
    snp_valid = 0; snp_cmd = C_NO;
    if (exp_fl == C_NO)
      chk(!flush_valid, req, "no flush", {31'd0, flush_valid}, 0);
    else
      chk(flush_valid && flush_cmd == exp_fl && flush_addr == a && flush_data == exp_fd,
          req, "flush answer", {flush_valid, flush_cmd, 4'd0, flush_addr, flush_data},
          {1'b1, exp_fl, 4'd0, a, exp_fd});
  endtask

  // R1 R10: reset state, invalid lines ignore snoops
  task automatic t_reset();
    chk(!pr_done && !bus_req && !copies_out && !flush_valid, "R1", "reset outputs",
        {pr_done, bus_req, copies_out, flush_valid}, 0);
    snoop("R10", C_RD, 8'h10, '0, 0, C_NO, '0);
    snoop("R10", C_RDX, 8'h21, '0, 0, C_NO, '0);
  endtask

  // R2 R4 R5 R6 R7 R8 R12
  task automatic t_exclusive_path();
    logic [DW-1:0] rd;
    proc_start(0, 8'h10, '0);
    expect_req("R2", C_RD, 8'h10, 0, '0);
    mem_reply(16'hAAAA, 0);
    wait_done("R2", rd);
    chk(rd == 16'hAAAA, "R2", "read miss data", rd, 16'hAAAA);
    hit_access("R6", 0, 8'h10, '0, 16'hAAAA);
    hit_access("R4", 1, 8'h10, 16'h1234, 16'h1234);
    snoop("R7", C_RD, 8'h10, '0, 1, C_FL, 16'h1234);   // M -> O, R12 copies
    snoop("R7", C_RD, 8'h10, '0, 1, C_FL, 16'h1234);   // O stays O
    proc_start(1, 8'h10, 16'h5678);
    expect_req("R5", C_UPG, 8'h10, 0, '0);
    wait_done("R5", rd);
    snoop("R8", C_RDX, 8'h10, '0, 0, C_FL, 16'h5678);  // M -> I
    snoop("R8", C_RD, 8'h10, '0, 0, C_NO, '0);
  endtask

  // R2 R3 R5 R10: shared fill, upgrade lost to a snoop
  task automatic t_shared_path();
    logic [DW-1:0] rd;
    proc_start(0, 8'h21, '0);
    expect_req("R2", C_RD, 8'h21, 0, '0);
    mem_reply(16'h1111, 1);
    wait_done("R2", rd);
    snoop("R10", C_RD, 8'h21, '0, 1, C_NO, '0);        // S: no flush
    proc_start(1, 8'h21, 16'h2222);
    @(negedge clk); @(negedge clk);
    chk(bus_req && bus_req_cmd == C_UPG, "R5", "upgrade from S",
        {28'd0, bus_req, bus_req_cmd}, {28'd0, 1'b1, C_UPG});
    snoop("R10", C_RDX, 8'h21, '0, 0, C_NO, '0);       // S -> I silently
    expect_req("R5", C_RDX, 8'h21, 0, '0);
    mem_reply(16'h9999, 0);
    wait_done("R3", rd);
    chk(rd == 16'h2222, "R3", "write miss data", rd, 16'h2222);
    snoop("R3", C_RD, 8'h21, '0, 1, C_FL, 16'h2222);   // was M, now O
  endtask

  // R9 R10 R8: exclusive line answers with optional flush
  task automatic t_exclusive_snoops();
    logic [DW-1:0] rd;
    proc_start(0, 8'h32, '0);
    expect_req("R2", C_RD, 8'h32, 0, '0);
    mem_reply(16'h3333, 0);
    wait_done("R2", rd);
    snoop("R9", C_RD, 8'h32, '0, 1, C_FLO, 16'h3333);  // E -> S
    snoop("R10", C_RD, 8'h32, '0, 1, C_NO, '0);        // now S
    snoop("R10", C_UPG, 8'h32, '0, 0, C_NO, '0);       // S -> I
    snoop("R10", C_RD, 8'h32, '0, 0, C_NO, '0);
    proc_start(0, 8'h32, '0);
    expect_req("R2", C_RD, 8'h32, 0, '0);
    mem_reply(16'h3434, 0);
    wait_done("R2", rd);
    snoop("R9", C_RDX, 8'h32, '0, 0, C_FLO, 16'h3434); // E -> I
    snoop("R9", C_RD, 8'h32, '0, 0, C_NO, '0);
  endtask

  // R11 R3 R8: write-back of dirty victims, silent drop of clean ones
  task automatic t_eviction();
    logic [DW-1:0] rd;
    proc_start(1, 8'h13, 16'h1357);
    expect_req("R3", C_RDX, 8'h13, 0, '0);
    mem_reply(16'hDEAD, 0);
    wait_done("R3", rd);
    proc_start(0, 8'h23, '0);
    expect_req("R11", C_WB, 8'h13, 1, 16'h1357);       // M victim
    expect_req("R11", C_RD, 8'h23, 0, '0);
    mem_reply(16'h2323, 0);
    wait_done("R11", rd);
    snoop("R11", C_RD, 8'h13, '0, 0, C_NO, '0);        // victim gone
    proc_start(0, 8'h33, '0);
    expect_req("R11", C_RD, 8'h33, 0, '0);              // E victim silent
    mem_reply(16'h3030, 1);
    wait_done("R11", rd);
    proc_start(0, 8'h03, '0);
    expect_req("R11", C_RD, 8'h03, 0, '0);              // S victim silent
    mem_reply(16'h0303, 0);
    wait_done("R11", rd);
    snoop("R8", C_UPG, 8'h21, '0, 0, C_NO, '0);        // O -> I, no flush
    proc_start(1, 8'h14, 16'h4444);
    expect_req("R3", C_RDX, 8'h14, 0, '0);
    mem_reply(16'h0, 0);
    wait_done("R3", rd);
    snoop("R7", C_RD, 8'h14, '0, 1, C_FL, 16'h4444);   // M -> O
    proc_start(0, 8'h24, '0);
    expect_req("R11", C_WB, 8'h14, 1, 16'h4444);       // O victim
    expect_req("R11", C_RD, 8'h24, 0, '0);
    mem_reply(16'h2424, 0);
    wait_done("R11", rd);
  endtask

  // R13: a matching cache flush completes the miss as Shared
  task automatic t_fill_from_flush();
    logic [DW-1:0] rd;
    proc_start(0, 8'h42, '0);
    expect_req("R13", C_RD, 8'h42, 0, '0);
    snoop("R13", C_FL, 8'h46, 16'hBEEF, 0, C_NO, '0);
    @(negedge clk);
    chk(!pr_done, "R13", "unrelated flush ignored", {31'd0, pr_done}, 0);
    snoop("R13", C_FLO, 8'h42, 16'h4242, 0, C_NO, '0);
    wait_done("R13", rd);
    chk(rd == 16'h4242, "R13", "flush fill data", rd, 16'h4242);
    snoop("R13", C_RD, 8'h42, '0, 1, C_NO, '0);        // Shared
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_exclusive_path();
    t_shared_path();
    t_exclusive_snoops();
    t_eviction();
    t_fill_from_flush();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule